// File: doc/BRIEF.md
# Four-Phase Stepper Head Positioner

This block follows the rotor of a four-phase stepper motor that carries a disk read head. The rotor angle lives on a circle of eight positions, and the four magnets sit at the even positions 0, 2, 4 and 6. Software or a controller sequencer energises or releases one phase per write. Each write names a phase and gives its new level. The other three phases keep their state.

The block acts after a write that changes the set of energised phases and leaves at least one phase on. It measures how far each energised magnet sits from the rotor, wrapped onto the circle. It averages those offsets over the number of energised magnets, and it turns the average into a signed head step in quarter-track units. The block reports that step with a single-cycle strobe and moves its position to match. Because the offsets are averaged, adjacent phases held together give half steps, and opposed magnets cancel out. The logic that consumes the step pulses keeps the track count.

Top module: `stepper_head_positioner`

## Requirements
- R1: After synchronous reset, the phase mask and the rotor position both read 0, step_valid is low and step_qtr is 0.
- R2: A write with phase_wr high sets bit phase_sel of the phase mask when phase_on is 1 and clears it when phase_on is 0. The other three bits keep their values. Phase n drives bit n, and its magnet sits at position 2n. The new mask shows on phase_mask one cycle after the write.
- R3: A write that leaves the phase mask unchanged produces no step strobe and leaves the rotor position where it was.
- R4: A write that leaves every phase off produces no step strobe and leaves the rotor position where it was.
- R5: A write that changes the mask and leaves it nonzero raises step_valid for the single following cycle. For each energised magnet the offset is ((pos - magnet + 4) mod 8) - 4, and these offsets are summed. The direction is that sum divided by the count of energised magnets, and step_qtr carries the negated direction as a 4-bit two's-complement value.
- R6: When step_valid is high, rotor_pos equals the previous position minus the direction, modulo 8. That equals the previous position plus step_qtr, modulo 8.
- R7: step_valid is high only in the cycle right after a phase write, and step_qtr reads 0 in every cycle when step_valid is low.
- R8: The division truncates toward zero. For example, at position 2 with phases 0, 2 and 3 on, the offsets sum to -4, the direction is -1 (not -2), the step is +1 and the new position is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_wr | input | 1 | Phase write strobe |
| phase_sel | input | 2 | Index of the phase being written |
| phase_on | input | 1 | New level of the selected phase |
| phase_mask | output | 4 | Energised phases, bit n is phase n |
| rotor_pos | output | 3 | Rotor position on the eight-step circle |
| step_valid | output | 1 | One-cycle strobe announcing a head step |
| step_qtr | output | 4 | Signed head step in quarter tracks, 0 when idle |

## Verification
A corrupted position register has a lasting effect. Every later offset is measured from the rotor position, so a wrong position changes the magnitude, and often the sign, of the next step, one cycle after the next phase write. It also stays visible on rotor_pos without waiting for any write. A wrong mask bit appears on phase_mask at once, and it skews the averaging divisor, so the damage shows in the following step value. A stuck strobe or a stale step value is seen in the idle cycle that follows each write, where step_valid must be low and step_qtr zero.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    localparam int PHASES   = 4;
    localparam int POS_W    = 3;
    localparam int SEL_W    = $clog2(PHASES);
    localparam int CNT_W    = $clog2(PHASES + 1);
    localparam int SUM_W    = 6;
    localparam int STEP_W   = 4;
    localparam int HALF_REV = (1 << POS_W) / 2;

    typedef logic [PHASES-1:0]        phase_mask_t;
    typedef logic [POS_W-1:0]         rotor_pos_t;
    typedef logic signed [SUM_W-1:0]  pull_sum_t;
    typedef logic signed [STEP_W-1:0] step_t;
    typedef logic [CNT_W-1:0]         coil_cnt_t;

    typedef struct packed {
        logic             wr;
        logic [SEL_W-1:0] sel;
        logic             on;
    } phase_cmd_t;

    typedef struct packed {
        logic  valid;
        step_t step;
    } head_move_t;

    // Signed angular distance from a magnet to the rotor, wrapped to [-4, +3].
    function automatic pull_sum_t wrap_offset(rotor_pos_t pos, rotor_pos_t magnet);
        rotor_pos_t wrapped;
        wrapped = pos - magnet + rotor_pos_t'(HALF_REV);
        return pull_sum_t'({1'b0, wrapped}) - pull_sum_t'(HALF_REV);
    endfunction

    // Sum divided by coil count (1..4), truncating toward zero.
    function automatic step_t div_trunc(pull_sum_t sum, coil_cnt_t cnt);
        logic       neg;
        logic [4:0] mag;
        logic [9:0] prod;
        logic [4:0] quo;
        pull_sum_t  qs;
        neg  = sum[SUM_W-1];
        mag  = neg ? 5'(-sum) : 5'(sum);
        prod = {5'b0, mag} * 10'd11;
        case (cnt)
            3'd1:    quo = mag;
            3'd2:    quo = mag >> 1;
            3'd3:    quo = prod[9:5];
            3'd4:    quo = mag >> 2;
            default: quo = '0;
        endcase
        qs = pull_sum_t'({1'b0, quo});
        return step_t'(neg ? -qs : qs);
    endfunction

endpackage

// File: rtl/stepper_phase_latch.sv
module stepper_phase_latch
    import stepper_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  phase_cmd_t  cmd,
    output phase_mask_t mask_q,
    output phase_mask_t mask_next,
    output logic        mask_changed
);

    always_comb begin
        mask_next = mask_q;
        if (cmd.wr) begin
            mask_next[cmd.sel] = cmd.on;
        end
        mask_changed = cmd.wr && (mask_next != mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_next;
        end
    end

endmodule

// File: rtl/stepper_pull_avg.sv
module stepper_pull_avg
    import stepper_pkg::*;
(
    input  phase_mask_t mask,
    input  rotor_pos_t  pos,
    output step_t       direction
);

    pull_sum_t offs [PHASES];

    genvar g;
    generate
        for (g = 0; g < PHASES; g++) begin : g_coil
            localparam rotor_pos_t MAGNET = rotor_pos_t'(2 * g);
            assign offs[g] = mask[g] ? wrap_offset(pos, MAGNET) : '0;
        end
    endgenerate

    pull_sum_t sum;
    coil_cnt_t cnt;

    always_comb begin
        sum = '0;
        cnt = '0;
        for (int i = 0; i < PHASES; i++) begin
            sum = sum + offs[i];
            cnt = cnt + coil_cnt_t'(mask[i]);
        end
        direction = div_trunc(sum, cnt);
    end

endmodule

// File: rtl/stepper_head_positioner.sv
module stepper_head_positioner
    import stepper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_wr,
    input  logic [1:0]        phase_sel,
    input  logic              phase_on,
    output logic [3:0]        phase_mask,
    output logic [2:0]        rotor_pos,
    output logic              step_valid,
    output logic signed [3:0] step_qtr
);

    phase_cmd_t  cmd;
    phase_mask_t mask_q;
    phase_mask_t mask_next;
    logic        mask_changed;
    rotor_pos_t  pos_q;
    step_t       direction;
    head_move_t  move_q;

    assign cmd = '{wr: phase_wr, sel: phase_sel, on: phase_on};

    stepper_phase_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .mask_q       (mask_q),
        .mask_next    (mask_next),
        .mask_changed (mask_changed)
    );

    stepper_pull_avg u_avg (
        .mask      (mask_next),
        .pos       (pos_q),
        .direction (direction)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            move_q <= '0;
        end else if (mask_changed && (mask_next != '0)) begin
            pos_q       <= pos_q - rotor_pos_t'(direction);
            move_q.valid <= 1'b1;
            move_q.step  <= -direction;
        end else begin
            move_q <= '0;
        end
    end

    assign phase_mask = mask_q;
    assign rotor_pos  = pos_q;
    assign step_valid = move_q.valid;
    assign step_qtr   = move_q.step;

endmodule

// File: rtl/stepper_head_positioner_chk.sv
module stepper_head_positioner_chk (
    input logic              clk,
    input logic              rst,
    input logic              phase_wr,
    input logic [3:0]        phase_mask,
    input logic [2:0]        rotor_pos,
    input logic              step_valid,
    input logic signed [3:0] step_qtr
);

    AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst) !phase_wr |=> !step_valid); // R7
    AST_IDLE_STEP_ZERO: assert property (@(posedge clk) disable iff (rst) !step_valid |-> step_qtr == 4'sd0); // R7
    AST_POS_TRACKS_STEP: assert property (@(posedge clk) disable iff (rst) step_valid |-> (rotor_pos - $past(rotor_pos)) == 3'(step_qtr)); // R6
    AST_POS_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst) !step_valid |-> $stable(rotor_pos)); // R3
    AST_ONE_BIT_PER_WRITE: assert property (@(posedge clk) disable iff (rst) $countones(phase_mask ^ $past(phase_mask)) <= 1); // R2
    AST_NO_STEP_ALL_OFF: assert property (@(posedge clk) disable iff (rst) step_valid |-> phase_mask != 4'd0); // R4
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst) step_valid |-> (step_qtr >= -4'sd3 && step_qtr <= 4'sd4)); // R5

endmodule

bind stepper_head_positioner stepper_head_positioner_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .phase_wr   (phase_wr),
    .phase_mask (phase_mask),
    .rotor_pos  (rotor_pos),
    .step_valid (step_valid),
    .step_qtr   (step_qtr)
);

// File: tb/stepper_head_positioner_tb_top.sv
`timescale 1ns/1ps
module stepper_head_positioner_tb_top;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              phase_wr = 1'b0;
    logic [1:0]        phase_sel = 2'd0;
    logic              phase_on = 1'b0;
    logic [3:0]        phase_mask;
    logic [2:0]        rotor_pos;
    logic              step_valid;
    logic signed [3:0] step_qtr;

    int n_checks = 0;
    int n_fails  = 0;
    int n_trunc  = 0;

    int m_mask = 0;
    int m_pos  = 0;

    always #4 clk = ~clk;

    stepper_head_positioner dut_i (
        .clk        (clk),
        .rst        (rst),
        .phase_wr   (phase_wr),
        .phase_sel  (phase_sel),
        .phase_on   (phase_on),
        .phase_mask (phase_mask),
        .rotor_pos  (rotor_pos),
        .step_valid (step_valid),
        .step_qtr   (step_qtr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        phase_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_mask = 0;
        m_pos  = 0;
        chk("R1 mask", int'(phase_mask), 0);
        chk("R1 pos", int'(rotor_pos), 0);
        chk("R1 valid", int'(step_valid), 0);
        chk("R1 step", int'(step_qtr), 0);
    endtask

    task automatic drive_phase(input int sel, input bit on);
        int nm, sum, cnt, dir, ev, es, ep;
        bit exact;
        nm = on ? (m_mask | (1 << sel)) : (m_mask & ~(1 << sel));
        ev = 0; es = 0; ep = m_pos; exact = 1'b1;
        if (nm != m_mask && nm != 0) begin
            sum = 0; cnt = 0;
            for (int k = 0; k < 4; k++) begin
                if (nm[k]) begin
                    sum += ((m_pos - 2 * k + 4) & 7) - 4;
                    cnt++;
                end
            end
            dir = sum / cnt;
            exact = (sum % cnt) == 0;
            ev = 1; es = -dir; ep = (m_pos - dir + 8) & 7;
            if (!exact && sum < 0) n_trunc++;
        end
        m_mask = nm;
        m_pos  = ep;
        @(negedge clk);
        phase_wr  = 1'b1;
        phase_sel = 2'(sel);
        phase_on  = on;
        @(negedge clk);
        phase_wr = 1'b0;
        chk("R2 mask", int'(phase_mask), nm);
        chk(ev ? "R5 valid" : "R3/R4 valid", int'(step_valid), ev);
        chk(exact ? "R5 step" : "R8 step", int'(step_qtr), es);
        chk("R6 pos", int'(rotor_pos), ep);
        @(negedge clk);
        chk("R7 strobe drop", int'(step_valid), 0);
        chk("R7 idle step", int'(step_qtr), 0);
    endtask

    task automatic t_forward_walk();
        do_reset();
        drive_phase(1, 1);
        drive_phase(0, 0);
        drive_phase(2, 1);
        drive_phase(1, 0);
        drive_phase(3, 1);
        drive_phase(2, 0);
        drive_phase(0, 1);
        drive_phase(3, 0);
        chk("R6 forward lap pos", int'(rotor_pos), 0);
    endtask

    task automatic t_reverse_and_half();
        do_reset();
        drive_phase(3, 1);
        drive_phase(2, 1);
        drive_phase(3, 0);
        drive_phase(1, 1);
        drive_phase(2, 0);
        drive_phase(0, 1);
    endtask

    task automatic t_redundant_and_off();
        do_reset();
        drive_phase(1, 1);
        drive_phase(1, 1);
        chk("R3 pos kept", int'(rotor_pos), 2);
        drive_phase(3, 0);
        drive_phase(1, 0);
        chk("R4 pos kept", int'(rotor_pos), 2);
        drive_phase(2, 0);
    endtask

    task automatic t_truncation();
        do_reset();
        drive_phase(1, 1);
        drive_phase(2, 1);
        drive_phase(0, 1);
        drive_phase(1, 0);
        drive_phase(3, 1);
        chk("R8 final pos", int'(rotor_pos), 3);
        drive_phase(1, 1);
        drive_phase(0, 0);
        drive_phase(2, 0);
        drive_phase(3, 0);
        drive_phase(0, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        t_forward_walk();
        t_reverse_and_half();
        t_redundant_and_off();
        t_truncation();
        n_checks++;
        if (n_trunc == 0) begin
            n_fails++;
            $display("FAIL R8 coverage: actual %0d expected >0", n_trunc);
        end
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule